// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block holds the interrupt presentation state of a single processor and drives that processor's interrupt line. It owns one pending slot, which holds a source number and its priority. Requests arriving from a source layer compete for that slot by priority. A request that loses is sent back with a reject pulse. A pending entry that is displaced by a more favoured request is also rejected back to its source.

The processor side issues four commands through a strobe, an opcode and a 32-bit data word: write the current processor priority, write the inter-processor request priority, accept, and end-of-interrupt. Inter-processor requests compete for the same slot under a reserved source number. Whenever the slot is found empty after a priority relaxation or an end-of-interrupt, the block asks the source layer to resend anything it is holding back. Each command or request takes effect at the next clock edge. Every response toward the source layer is a one-cycle pulse.

Top module: `irq_presenter`

## Requirements
- R1: After reset the interrupt output is low and all pulse outputs are idle. The current priority is 0, so every source request is rejected. The inter-processor priority is 0xff.
- R2: The state word has the current priority in bits 31:24 and the pending source in bits 23:0. Source 0 means empty. A smaller priority number is more favoured, and 0xff is least favoured.
- R3: A source request is rejected when its priority is not strictly below the current priority, or when a pending entry has a priority less than or equal to it. The reject pulse follows on the next cycle and carries the requested source.
- R4: A request that wins while another entry is pending rejects the old source in the same cycle that it latches the new source and priority. The interrupt output goes high.
- R5: Accept (opcode 2) returns the old state word on the next cycle with a valid pulse and lowers the output. The source field is cleared, and the current priority becomes the priority of the entry just taken.
- R6: End-of-interrupt (opcode 3) loads the current priority from data bits 31:24 and pulses the end-of-interrupt output with data bits 23:0. If the slot is empty, the resend procedure (R9) runs.
- R7: A current-priority write (opcode 0, data bits 31:24) that lowers the value clears a pending entry whose priority is at least the new value. That entry is rejected and the output falls. A write that does not lower the value runs the resend procedure when the slot is empty.
- R8: An inter-processor priority write (opcode 1, data bits 7:0) stores the value. If the value is below the current priority, the slot check runs. The check keeps a pending entry whose priority is less than or equal to the stored value. Otherwise it rejects that entry and loads source 2 with the stored priority, and the output goes high.
- R9: The resend procedure runs the R8 slot check when the inter-processor priority is below the current priority. In every case it then emits a one-cycle resend pulse.
- R10: The interrupt output is high exactly when the pending source field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 priority, 1 inter-processor priority, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command data word |
| req_valid | input | 1 | Source presentation request strobe |
| req_src | input | 24 | Requested source number |
| req_prio | input | 8 | Requested priority |
| irq_out | output | 1 | Interrupt line to the processor |
| acc_valid | output | 1 | Accept result pulse |
| acc_word | output | 32 | State word returned by accept (zero otherwise) |
| rej_valid | output | 1 | Reject pulse to source layer |
| rej_src | output | 24 | Rejected source number |
| resend_pulse | output | 1 | Resend request to source layer |
| eoi_valid | output | 1 | End-of-interrupt pulse to source layer |
| eoi_src | output | 24 | Source number being ended |

## Verification
The assertions assume that the command strobe and the request strobe are never high in the same cycle, and that requests never carry source 0. If both strobes were high, the command would win and the request would be lost silently. The bench respects both assumptions in its directed and random phases: each cycle carries either one command, one request or nothing, and random source numbers are drawn from a nonzero range. Random priorities include 0xff and values close to the current priority, so that ties and masking are exercised.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W = 24,
  parameter int PRIO_W = 8,
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [SRC_W+PRIO_W-1:0]  cmd_data,
  input  logic                     req_valid,
  input  logic [SRC_W-1:0]         req_src,
  input  logic [PRIO_W-1:0]        req_prio,
  output logic                     irq_out,
  output logic                     acc_valid,
  output logic [SRC_W+PRIO_W-1:0]  acc_word,
  output logic                     rej_valid,
  output logic [SRC_W-1:0]         rej_src,
  output logic                     resend_pulse,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src
);
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] LEAST = {PRIO_W{1'b1}};
  localparam logic [1:0] OP_CPPR = 2'd0, OP_MFRR = 2'd1, OP_ACC = 2'd2, OP_EOI = 2'd3;

  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q, n_cppr, n_pend, n_mfrr;
  logic [SRC_W-1:0]  xisr_q, n_xisr, n_rej_src, n_eoi_src;
  logic [WORD_W-1:0] n_acc_word;
  logic              irq_q, n_irq, n_rej, n_resend, n_eoi, n_acc, chk;

  always_comb begin
    n_cppr = cppr_q;
    n_xisr = xisr_q;
    n_pend = pend_q;
    n_mfrr = mfrr_q;
    n_irq = irq_q;
    n_rej = 1'b0;
    n_rej_src = '0;
    n_resend = 1'b0;
    n_eoi = 1'b0;
    n_eoi_src = '0;
    n_acc = 1'b0;
    n_acc_word = '0;
    chk = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_CPPR: begin
          n_cppr = cmd_data[WORD_W-1:SRC_W];
          if (n_cppr < cppr_q) begin
            if (xisr_q != '0 && n_cppr <= pend_q) begin
              n_xisr = '0;
              n_irq = 1'b0;
              n_rej = 1'b1;
              n_rej_src = xisr_q;
            end
          end else if (xisr_q == '0) begin
            n_resend = 1'b1;
            chk = mfrr_q < n_cppr;
          end
        end
        OP_MFRR: begin
          n_mfrr = cmd_data[PRIO_W-1:0];
          chk = n_mfrr < cppr_q;
        end
        OP_ACC: begin
          n_acc = 1'b1;
          n_acc_word = {cppr_q, xisr_q};
          n_cppr = pend_q;
          n_xisr = '0;
          n_irq = 1'b0;
        end
        default: begin
          n_cppr = cmd_data[WORD_W-1:SRC_W];
          n_eoi = 1'b1;
          n_eoi_src = cmd_data[SRC_W-1:0];
          if (xisr_q == '0) begin
            n_resend = 1'b1;
            chk = mfrr_q < n_cppr;
          end
        end
      endcase
    end else if (req_valid) begin
      if (req_prio >= cppr_q || (xisr_q != '0 && pend_q <= req_prio)) begin
        n_rej = 1'b1;
        n_rej_src = req_src;
      end else begin
        if (xisr_q != '0) begin
          n_rej = 1'b1;
          n_rej_src = xisr_q;
        end
        n_xisr = req_src;
        n_pend = req_prio;
        n_irq = 1'b1;
      end
    end
    if (chk && !(n_xisr != '0 && n_pend <= n_mfrr)) begin
      if (n_xisr != '0) begin
        n_rej = 1'b1;
        n_rej_src = n_xisr;
      end
      n_xisr = IPI_SRC;
      n_pend = n_mfrr;
      n_irq = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= '0;
      xisr_q <= '0;
      pend_q <= '0;
      mfrr_q <= LEAST;
      irq_q <= 1'b0;
      acc_valid <= 1'b0;
      acc_word <= '0;
      rej_valid <= 1'b0;
      rej_src <= '0;
      resend_pulse <= 1'b0;
      eoi_valid <= 1'b0;
      eoi_src <= '0;
    end else begin
      cppr_q <= n_cppr;
      xisr_q <= n_xisr;
      pend_q <= n_pend;
      mfrr_q <= n_mfrr;
      irq_q <= n_irq;
      acc_valid <= n_acc;
      acc_word <= n_acc_word;
      rej_valid <= n_rej;
      rej_src <= n_rej_src;
      resend_pulse <= n_resend;
      eoi_valid <= n_eoi;
      eoi_src <= n_eoi_src;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
  parameter int SRC_W = 24,
  parameter int PRIO_W = 8,
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [1:0]              cmd_op,
  input logic [SRC_W+PRIO_W-1:0] cmd_data,
  input logic                    req_valid,
  input logic [SRC_W-1:0]        req_src,
  input logic [PRIO_W-1:0]       req_prio,
  input logic                    irq_out,
  input logic                    acc_valid,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic [SRC_W-1:0]        xisr_q,
  input logic [PRIO_W-1:0]       cppr_q
);
  a_r10_line_matches_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (xisr_q != '0));

  a_r5_accept_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> (acc_valid && !irq_out && xisr_q == '0));

  a_r6_eoi_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));

  a_r3_masked_request_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && req_valid && req_prio >= cppr_q) |=> (rej_valid && rej_src == $past(req_src)));

  a_r8_ipi_fills_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_data[PRIO_W-1:0] < cppr_q && xisr_q == '0)
      |=> (irq_out && xisr_q == IPI_SRC));
endmodule

bind irq_presenter irq_presenter_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
  .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio), .irq_out(irq_out),
  .acc_valid(acc_valid), .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
  .eoi_src(eoi_src), .xisr_q(xisr_q), .cppr_q(cppr_q)
);

// File: tb/tb_irq_presenter.sv
module tb_irq_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = 32'd0;
  logic        req_valid = 1'b0;
  logic [23:0] req_src = 24'd0;
  logic [7:0]  req_prio = 8'd0;
  logic        irq_out, acc_valid, rej_valid, resend_pulse, eoi_valid;
  logic [31:0] acc_word;
  logic [23:0] rej_src, eoi_src;

  irq_presenter dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio), .irq_out(irq_out),
    .acc_valid(acc_valid), .acc_word(acc_word), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_pulse(resend_pulse), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  always #2.5ns clk = ~clk;

  int checks = 0, fails = 0;
  int m_cppr = 0, m_xisr = 0, m_pend = 0, m_mfrr = 255, m_irq = 0;
  int e_acc = 0, e_acc_word = 0, e_rej = 0, e_rej_src = 0, e_resend = 0, e_eoi = 0, e_eoi_src = 0;
  string prev_tag = "R1";

  task automatic m_reject(input int s);
    e_rej = 1;
    e_rej_src = s;
  endtask

  task automatic m_check();
    if (m_xisr != 0 && m_pend <= m_mfrr) return;
    if (m_xisr != 0) m_reject(m_xisr);
    m_xisr = 2;
    m_pend = m_mfrr;
    m_irq = 1;
  endtask

  task automatic m_resend();
    if (m_mfrr < m_cppr) m_check();
    e_resend = 1;
  endtask

  task automatic model(input bit cv, input int op, input int d, input bit rv, input int rs, input int rp);
    int hi, lo, old;
    hi = (d >> 24) & 255;
    lo = d & 24'hffffff;
    e_acc = 0; e_acc_word = 0; e_rej = 0; e_rej_src = 0;
    e_resend = 0; e_eoi = 0; e_eoi_src = 0;
    if (cv) begin
      if (op == 0) begin
        old = m_cppr;
        m_cppr = hi;
        if (hi < old) begin
          if (m_xisr != 0 && hi <= m_pend) begin
            m_reject(m_xisr);
            m_xisr = 0;
            m_irq = 0;
          end
        end else if (m_xisr == 0) m_resend();
      end else if (op == 1) begin
        m_mfrr = d & 255;
        if (m_mfrr < m_cppr) m_check();
      end else if (op == 2) begin
        e_acc = 1;
        e_acc_word = (m_cppr << 24) | m_xisr;
        m_cppr = m_pend;
        m_xisr = 0;
        m_irq = 0;
      end else begin
        m_cppr = hi;
        e_eoi = 1;
        e_eoi_src = lo;
        if (m_xisr == 0) m_resend();
      end
    end else if (rv) begin
      if (rp >= m_cppr || (m_xisr != 0 && m_pend <= rp)) m_reject(rs);
      else begin
        if (m_xisr != 0) m_reject(m_xisr);
        m_xisr = rs;
        m_pend = rp;
        m_irq = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [84:0] act, exp;
    act = {irq_out, acc_valid, acc_word, rej_valid, rej_src, resend_pulse, eoi_valid, eoi_src};
    exp = {m_irq[0], e_acc[0], e_acc_word[31:0], e_rej[0], e_rej_src[23:0], e_resend[0],
           e_eoi[0], e_eoi_src[23:0]};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit cv, input int op, input int d,
                      input bit rv, input int rs, input int rp);
    @(negedge clk);
    compare(prev_tag);
    cmd_valid = cv;
    cmd_op = op[1:0];
    cmd_data = d;
    req_valid = rv;
    req_src = rs[23:0];
    req_prio = rp[7:0];
    model(cv, op, d, rv, rs, rp);
    prev_tag = tag;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 1, 100, 5);
    step("R7", 1, 0, 32'hff000000, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 100, 5);
    step("R3", 0, 0, 0, 1, 200, 7);
    step("R4", 0, 0, 0, 1, 300, 3);
    step("R3", 0, 0, 0, 1, 400, 3);
    step("R5", 1, 2, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 500, 2);
    step("R6", 1, 3, 32'hff00012c, 0, 0, 0);
    step("R7", 1, 0, 32'h01000000, 0, 0, 0);
    step("R8", 1, 1, 0, 0, 0, 0);
    step("R5", 1, 2, 0, 0, 0, 0);
    step("R9", 1, 3, 32'hff000002, 0, 0, 0);
    step("R8", 1, 1, 255, 0, 0, 0);
    step("R5", 1, 2, 0, 0, 0, 0);
    step("R9", 1, 0, 32'hff000000, 0, 0, 0);
    step("R8", 1, 1, 4, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 60, 6);
    step("R4", 0, 0, 0, 1, 77, 2);
    step("R8", 1, 1, 3, 0, 0, 0);
    step("R10", 1, 2, 0, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      int k, p, s;
      k = $urandom % 7;
      p = ($urandom % 5 == 0) ? 255 : $urandom % 8;
      s = 1 + $urandom % 40;
      case (k)
        0, 1:    step("R3", 0, 0, 0, 1, s, p);
        2:       step("R7", 1, 0, p << 24, 0, 0, 0);
        3:       step("R8", 1, 1, p, 0, 0, 0);
        4:       step("R5", 1, 2, 0, 0, 0, 0);
        5:       step("R6", 1, 3, (p << 24) | s, 0, 0, 0);
        default: step("R10", 0, 0, 0, 0, 0, 0);
      endcase
    end
    step("R2", 1, 2, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare(prev_tag);
    summary();
    $finish;
  end
endmodule